// File: doc/BRIEF.md
# Dual Down-Counting Bus Timer

This block is a memory-mapped peripheral that holds a parameterised number of independent down-counters. The default is two. The counters sit behind a simple single-cycle register bus. Each counter is programmed with a reload value and a control byte. After that it counts down on prescaled ticks of the block clock and raises a level interrupt each time it reaches zero. What happens after zero depends on the mode: the counter reloads (periodic), wraps to all ones (free-running) or stops (one-shot).

Software uses one counter as a free-running time base and the other as an event timer. A background reload register lets software change the period of a running periodic counter without disturbing the count already in progress. Eight read-only byte registers at the top of the 4 KB map identify the peripheral.

A write takes place in any cycle where `bus_sel`, `bus_en` and `bus_wr` are all high. Read data is a combinational decode of `bus_addr`. Address bits 1:0 are ignored.

Top module: `dual_dcount_timer`

## Requirements
- R1: Counter k owns the 32-byte window that starts at 0x20*k. Its registers are: reload value at +0x00, current count at +0x04, control at +0x08, interrupt clear at +0x0C, raw flag at +0x10 (bit 0), masked flag at +0x14 (bit 0) and background reload at +0x18. The clear register reads zero. Offset +0x1C, windows beyond the last counter and every other unmapped address also read zero.
- R2: After reset every control register is zero, every reload value and count is 0xFFFFFFFF, every raw flag is clear and every interrupt output is low.
- R3: The control byte fields are: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale, bit 1 32-bit size and bit 0 one-shot. The control register reads back these bits. Bit 4 and bits 31:8 read zero.
- R4: A running counter ticks on every cycle with prescale 00, once per 16 running cycles with 01, and once per 256 running cycles with 10 or 11. A write to the reload register restarts the prescaler.
- R5: On each tick a non-zero count decrements by one. The tick that takes the count from 1 to 0 sets the raw flag.
- R6: The tick after the count reaches zero depends on the mode. With one-shot set, the count stays at zero until the next reload write. Otherwise, periodic loads the reload value and free-running loads the all-ones value of the selected width.
- R7: A write to the reload register sets both the reload value and the count at once, and it overrides a tick in the same cycle. A write to the background reload register changes only the reload value. Both registers read back the reload value.
- R8: With bit 1 clear, only the low 16 bits count and wrap, and bits 31:16 of the count register read zero.
- R9: A write of any value to a counter's clear register clears its raw flag. If the counter reaches zero in the same cycle, the flag stays set.
- R10: The masked flag equals the raw flag AND the interrupt enable bit. `tmr_irq[k]` is counter k's masked flag, and `tmr_irq_any` is the OR of all of them.
- R11: While the run bit is clear, the count and the prescaler hold. Setting the run bit again resumes counting from the held state.
- R12: Writes to the count register are ignored.
- R13: For i in 0..3, address 0xFE0+4*i returns byte i of `PERIPH_ID` and 0xFF0+4*i returns byte i of `CELL_ID`, both in bits 7:0 with bits 31:8 zero. Byte 0 is the least significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock for bus and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access phase enable |
| bus_wr | input | 1 | High for a write |
| bus_addr | input | 12 | Byte address within the 4 KB map |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tmr_irq | output | N_TMR | Per-counter level interrupt |
| tmr_irq_any | output | 1 | OR of all counter interrupts |

## Verification
The hardest situation to reach is a clear write that lands in exactly the cycle in which the counter steps from 1 to 0, where the new event has to win. To get there, the stimulus runs a periodic counter with a reload of 1, so it reaches zero on every second cycle. It then issues clear writes at both cycle phases, which puts at least one of them on a zero event. The free-running 16-bit wrap and the one-shot stop are reached from small reload values. Freezing is tested by clearing the run bit part-way through a prescaled period and checking that the remaining ticks come out only after it is set again.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

   typedef enum logic [2:0] {
      REG_LOAD   = 3'd0,
      REG_VALUE  = 3'd1,
      REG_CTRL   = 3'd2,
      REG_CLR    = 3'd3,
      REG_RAW    = 3'd4,
      REG_MASKED = 3'd5,
      REG_BG     = 3'd6,
      REG_NONE   = 3'd7
   } dtmr_reg_e;

   typedef struct packed {
      logic       run;
      logic       periodic;
      logic       irq_en;
      logic [1:0] div;
      logic       wide;
      logic       single;
   } dtmr_ctrl_t;

   // field bits {7,6,5,3,2,1,0} of the control byte
   function automatic dtmr_ctrl_t ctrl_unpack(logic [6:0] f);
      dtmr_ctrl_t c;
      c.run      = f[6];
      c.periodic = f[5];
      c.irq_en   = f[4];
      c.div      = f[3:2];
      c.wide     = f[1];
      c.single   = f[0];
      return c;
   endfunction

   function automatic logic [7:0] ctrl_pack(dtmr_ctrl_t c);
      return {c.run, c.periodic, c.irq_en, 1'b0, c.div, c.wide, c.single};
   endfunction

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
   parameter int PRE_W   = 8,
   parameter int MID_LOG = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] div,
   output logic       tick
);
   generate
      if (MID_LOG < 1 || MID_LOG >= PRE_W) begin : g_bad_mid
         $error("dtmr_prescale: MID_LOG must lie in 1..PRE_W-1");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic             mid_done;
   logic             full_done;

   assign mid_done  = &pre_q[MID_LOG-1:0];
   assign full_done = &pre_q;

   always_comb begin
      unique case (div)
         2'b00:   tick = run;
         2'b01:   tick = run && mid_done;
         default: tick = run && full_done;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else if (run)     pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
   import dtmr_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16,
   parameter int PRE_W    = 8,
   parameter int MID_LOG  = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_load,
   input  logic        wr_ctrl,
   input  logic        wr_clr,
   input  logic        wr_bg,
   input  logic [31:0] wdata,
   input  dtmr_reg_e   rsel,
   output logic [31:0] rdata,
   output logic        irq
);
   generate
      if (CNT_W > 32 || CNT_W <= NARROW_W) begin : g_bad_width
         $error("dtmr_channel: need NARROW_W < CNT_W <= 32");
      end
   endgenerate

   localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [CNT_W-1:0] ONE         = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] load_q, cnt_q, cnt_d, mask, cur;
   dtmr_ctrl_t       ctrl_q;
   logic             raw_q, tick, hit;

   dtmr_prescale #(.PRE_W(PRE_W), .MID_LOG(MID_LOG)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .restart (wr_load),
      .div     (ctrl_q.div),
      .tick    (tick)
   );

   assign mask = ctrl_q.wide ? '1 : NARROW_MASK;
   assign cur  = cnt_q & mask;

   always_comb begin
      cnt_d = cnt_q;
      hit   = 1'b0;
      if (tick) begin
         if (cur != '0) begin
            cnt_d = (cur - ONE) & mask;
            hit   = (cur == ONE);
         end else if (ctrl_q.single) begin
            cnt_d = cur;
         end else if (ctrl_q.periodic) begin
            cnt_d = load_q & mask;
         end else begin
            cnt_d = mask;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '1;
         cnt_q  <= '1;
         ctrl_q <= '0;
         raw_q  <= 1'b0;
      end else begin
         if (wr_load) begin
            load_q <= wdata[CNT_W-1:0];
            cnt_q  <= wdata[CNT_W-1:0];
         end else begin
            cnt_q  <= cnt_d;
            if (wr_bg) load_q <= wdata[CNT_W-1:0];
         end
         if (wr_ctrl) ctrl_q <= ctrl_unpack({wdata[7:5], wdata[3:0]});
         if (hit)         raw_q <= 1'b1;
         else if (wr_clr) raw_q <= 1'b0;
      end
   end

   assign irq = raw_q & ctrl_q.irq_en;

   always_comb begin
      rdata = '0;
      unique case (rsel)
         REG_LOAD, REG_BG: rdata[CNT_W-1:0] = load_q;
         REG_VALUE:        rdata[CNT_W-1:0] = cur;
         REG_CTRL:         rdata[7:0]       = ctrl_pack(ctrl_q);
         REG_RAW:          rdata[0]         = raw_q;
         REG_MASKED:       rdata[0]         = irq;
         default:          rdata            = '0;
      endcase
   end
endmodule

// File: rtl/dual_dcount_timer.sv
module dual_dcount_timer
   import dtmr_pkg::*;
#(
   parameter int          N_TMR     = 2,
   parameter int          CNT_W     = 32,
   parameter int          NARROW_W  = 16,
   parameter int          PRE_W     = 8,
   parameter int          MID_LOG   = 4,
   parameter logic [31:0] PERIPH_ID = 32'h0047_1D52,
   parameter logic [31:0] CELL_ID   = 32'h9C3E_A061
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_en,
   input  logic             bus_wr,
   input  logic [11:0]      bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic [N_TMR-1:0] tmr_irq,
   output logic             tmr_irq_any
);
   localparam int          SLOT_W  = 7;
   localparam logic [6:0]  ID_SLOT = 7'h7F;

   generate
      if (N_TMR < 1 || N_TMR > 64) begin : g_bad_count
         $error("dual_dcount_timer: N_TMR must lie in 1..64");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   dtmr_reg_e         rsel;
   logic              wr_any;
   logic [31:0]       ch_rdata [N_TMR];
   logic              unused_addr_lsb;

   assign slot            = bus_addr[11:5];
   assign rsel            = dtmr_reg_e'(bus_addr[4:2]);
   assign wr_any          = bus_sel & bus_en & bus_wr;
   assign unused_addr_lsb = ^bus_addr[1:0];

   generate
      for (genvar k = 0; k < N_TMR; k++) begin : g_ch
         logic mine;
         assign mine = wr_any && (slot == SLOT_W'(k));
         dtmr_channel #(
            .CNT_W(CNT_W), .NARROW_W(NARROW_W), .PRE_W(PRE_W), .MID_LOG(MID_LOG)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_load (mine && rsel == REG_LOAD),
            .wr_ctrl (mine && rsel == REG_CTRL),
            .wr_clr  (mine && rsel == REG_CLR),
            .wr_bg   (mine && rsel == REG_BG),
            .wdata   (bus_wdata),
            .rsel    (rsel),
            .rdata   (ch_rdata[k]),
            .irq     (tmr_irq[k])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (slot == ID_SLOT) begin
         bus_rdata[7:0] = bus_addr[4] ? CELL_ID[8*bus_addr[3:2] +: 8]
                                      : PERIPH_ID[8*bus_addr[3:2] +: 8];
      end else begin
         for (int k = 0; k < N_TMR; k++) begin
            if (slot == SLOT_W'(k)) bus_rdata = ch_rdata[k];
         end
      end
   end

   assign tmr_irq_any = |tmr_irq;
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chan_chk
   import dtmr_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_load,
   input logic             wr_clr,
   input logic [31:0]      wdata,
   input dtmr_reg_e        rsel,
   input logic [31:0]      rdata,
   input logic             raw_q,
   input logic [CNT_W-1:0] cnt_q,
   input dtmr_ctrl_t       ctrl_q
);
   // R11
   frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !wr_load) |=> $stable(cnt_q));

   // R8
   narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel == REG_VALUE && !ctrl_q.wide) |-> ((rdata >> NARROW_W) == '0));

   // R6
   oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.single && cnt_q == '0 && !wr_load) |=> (cnt_q == '0));

   // R9
   raw_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(raw_q) |-> $past(wr_clr));

   // R5
   raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q) |-> (cnt_q == '0 || $past(wr_load)));

   // R7
   load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> (cnt_q == $past(wdata[CNT_W-1:0])));
endmodule

module dtmr_top_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [11:0] bus_addr,
   input logic [31:0] bus_rdata
);
   // R13
   id_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[11:5] == 7'h7F) |-> (bus_rdata[31:8] == 24'h0));

   // R1
   gap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[11:5] != 7'h7F && bus_addr[4:2] == 3'd7) |-> (bus_rdata == 32'h0));
endmodule

bind dtmr_channel dtmr_chan_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chan_chk (
   .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .wr_clr(wr_clr), .wdata(wdata),
   .rsel(rsel), .rdata(rdata), .raw_q(raw_q), .cnt_q(cnt_q), .ctrl_q(ctrl_q)
);

bind dual_dcount_timer dtmr_top_chk u_top_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/dual_dcount_timer_test.sv
`timescale 1ns/1ps
module dual_dcount_timer_test;
   localparam logic [31:0] PID = 32'h0047_1D52;
   localparam logic [31:0] CID = 32'h9C3E_A061;

   logic        clk = 0, rst_n = 0;
   logic        bus_sel = 0, bus_en = 0, bus_wr = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  tmr_irq;
   logic        tmr_irq_any;

   dual_dcount_timer #(.N_TMR(2), .PERIPH_ID(PID), .CELL_ID(CID)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tmr_irq(tmr_irq), .tmr_irq_any(tmr_irq_any)
   );

   always #2.5 clk = ~clk;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // behavioural reference model
   logic [31:0] m_ld [2];
   logic [31:0] m_val[2];
   logic [7:0]  m_ctl[2];
   bit          m_raw[2];
   int          m_pre[2];

   task automatic m_reset();
      for (int c = 0; c < 2; c++) begin
         m_ld[c] = 32'hFFFF_FFFF; m_val[c] = 32'hFFFF_FFFF;
         m_ctl[c] = 8'h00; m_raw[c] = 0; m_pre[c] = 0;
      end
   endtask

   task automatic m_step();
      for (int c = 0; c < 2; c++) begin
         bit acc, tick, ev;
         int r, ps;
         logic [31:0] mask, cur, nv;
         acc  = bus_sel && bus_en && bus_wr && (int'(bus_addr[11:5]) == c);
         r    = int'(bus_addr[4:2]);
         ps   = int'(m_ctl[c][3:2]);
         mask = m_ctl[c][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
         tick = 0;
         if (m_ctl[c][7]) begin
            if (ps == 0)      tick = 1;
            else if (ps == 1) tick = (m_pre[c] % 16) == 15;
            else              tick = (m_pre[c] == 255);
            m_pre[c] = (m_pre[c] + 1) % 256;
         end
         cur = m_val[c] & mask;
         nv  = m_val[c];
         ev  = 0;
         if (tick) begin
            if (cur != 0) begin
               nv = cur - 1;
               ev = (nv == 0);
            end else if (m_ctl[c][0]) nv = 0;
            else if (m_ctl[c][6])     nv = m_ld[c] & mask;
            else                      nv = mask;
         end
         m_val[c] = nv;
         if (acc && r == 3) m_raw[c] = 0;
         if (ev)            m_raw[c] = 1;
         if (acc) begin
            case (r)
               0: begin m_ld[c] = bus_wdata; m_val[c] = bus_wdata; m_pre[c] = 0; end
               2: m_ctl[c] = bus_wdata[7:0] & 8'hEF;
               6: m_ld[c] = bus_wdata;
               default: ;
            endcase
         end
      end
   endtask

   function automatic logic [31:0] m_read(logic [11:0] a);
      int s, r, c;
      s = int'(a[11:5]); r = int'(a[4:2]);
      if (s == 127) return {24'h0, (a[4] ? CID : PID) >> (8 * int'(a[3:2]))} & 32'hFF;
      if (s >= 2) return 32'h0;
      c = s;
      case (r)
         0, 6: return m_ld[c];
         1:    return m_val[c] & (m_ctl[c][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
         2:    return {24'h0, m_ctl[c]};
         4:    return {31'h0, m_raw[c]};
         5:    return {31'h0, m_raw[c] & m_ctl[c][5]};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else        m_step();
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // R10: interrupt outputs compared against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [1:0] e;
         for (int c = 0; c < 2; c++) e[c] = m_raw[c] & m_ctl[c][5];
         chk("R10 tmr_irq", {30'h0, tmr_irq}, {30'h0, e});
         chk("R10 tmr_irq_any", {31'h0, tmr_irq_any}, {31'h0, |e});
      end
   end

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_en = 0; bus_wr = 0;
   endtask

   task automatic rd(logic [11:0] a, string tag);
      @(negedge clk);
      bus_addr = a; bus_sel = 1; bus_wr = 0;
      #1 chk(tag, bus_rdata, m_read(a));
      bus_sel = 0;
   endtask

   task automatic rd_const(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = a; bus_sel = 1; bus_wr = 0;
      #1 chk(tag, bus_rdata, exp);
      bus_sel = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2 reset state
      rd_const(12'h000, 32'hFFFF_FFFF, "R2 load0 reset");
      rd_const(12'h004, 32'h0000_FFFF, "R2 value0 reset (16-bit after reset)");
      rd_const(12'h008, 32'h0, "R2 ctrl0 reset");
      rd_const(12'h010, 32'h0, "R2 raw0 reset");
      rd_const(12'h020, 32'hFFFF_FFFF, "R2 load1 reset");
      // R13 identification bytes
      for (int i = 0; i < 4; i++) begin
         rd_const(12'hFE0 + 12'(4 * i), {24'h0, PID[8*i +: 8]}, "R13 periph id");
         rd_const(12'hFF0 + 12'(4 * i), {24'h0, CID[8*i +: 8]}, "R13 cell id");
      end
      // R1 unmapped and write-only reads
      rd_const(12'h01C, 32'h0, "R1 gap 0x1C");
      rd_const(12'h040, 32'h0, "R1 beyond last window");
      rd_const(12'h800, 32'h0, "R1 mid map");
      rd_const(12'h00C, 32'h0, "R1 clear reads zero");
      // R3 control readback drops bit 4 and upper bits
      wr(12'h008, 32'hFFFF_FF32);
      rd_const(12'h008, 32'h0000_0022, "R3 ctrl readback");
      // R12 value writes ignored
      wr(12'h004, 32'h0000_1234);
      rd_const(12'h004, 32'hFFFF_FFFF, "R12 value write ignored");
      // R5 R6 periodic, divide by 1
      wr(12'h000, 32'd5);
      wr(12'h008, 32'hE2);
      for (int i = 0; i < 10; i++) rd(12'h004, "R5 periodic count");
      idle(6);
      rd(12'h010, "R5 raw set");
      rd(12'h014, "R10 masked");
      wr(12'h00C, 32'hDEAD_BEEF);
      rd(12'h010, "R9 clear");
      // R7 background reload
      wr(12'h018, 32'd2);
      rd_const(12'h000, 32'd2, "R7 bg changes reload");
      for (int i = 0; i < 12; i++) rd(12'h004, "R7 bg then count");
      // R11 freeze and resume
      wr(12'h000, 32'd40);
      wr(12'h008, 32'h62);
      rd(12'h004, "R11 frozen");
      idle(5);
      rd(12'h004, "R11 still frozen");
      wr(12'h008, 32'hE2);
      idle(3);
      rd(12'h004, "R11 resumed");
      // R4 divide by 16, freeze mid-period
      wr(12'h008, 32'hE6);
      wr(12'h000, 32'd3);
      idle(9);
      wr(12'h008, 32'h66);
      idle(20);
      rd(12'h004, "R4 R11 prescaler frozen");
      wr(12'h008, 32'hE6);
      for (int i = 0; i < 20; i++) begin idle(3); rd(12'h004, "R4 div16"); end
      // R4 divide by 256 via code 11
      wr(12'h008, 32'hEE);
      wr(12'h000, 32'd2);
      idle(600);
      rd(12'h004, "R4 div256");
      rd(12'h010, "R4 div256 raw");
      // R8 R6 free-running 16-bit on counter 1
      wr(12'h020, 32'h0003_0002);
      wr(12'h028, 32'hA0);
      for (int i = 0; i < 6; i++) rd(12'h024, "R8 R6 free16 wrap");
      rd(12'h030, "R1 raw1");
      wr(12'h02C, 32'h0);
      // R6 free-running 32-bit wrap
      wr(12'h020, 32'd2);
      wr(12'h028, 32'hA2);
      for (int i = 0; i < 4; i++) rd(12'h024, "R6 free32 wrap");
      // R6 one-shot overrides periodic
      wr(12'h028, 32'hE3);
      wr(12'h020, 32'd4);
      idle(10);
      rd(12'h024, "R6 oneshot holds");
      wr(12'h020, 32'd2);
      idle(5);
      rd(12'h024, "R6 oneshot reload");
      rd(12'h030, "R6 oneshot raw");
      // R9 clear colliding with zero event, both phases
      wr(12'h02C, 32'h0);
      wr(12'h020, 32'd1);
      wr(12'h028, 32'hE2);
      for (int i = 0; i < 6; i++) begin
         wr(12'h02C, 32'h1);
         rd(12'h030, "R9 clear vs event");
         if (i % 2 == 1) idle(1);
      end
      // R10 interrupt enable off masks output
      wr(12'h008, 32'hC2);
      rd(12'h010, "R10 raw with enable off");
      rd(12'h014, "R10 masked with enable off");
      rd(12'h038, "R7 bg read ch1");
      rd(12'h034, "R10 masked ch1");
      idle(10);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule